// File: doc/BRIEF.md
# Analyzer Front-End Configuration Sequencer

This block produces the byte stream that configures a nine-channel logic-analyzer front end over a byte-wide link. Each command on that link is two bytes: a register address with its top bit set, followed by a value. The block holds two fixed scripts. An init request plays the power-up script, and a start request plays the script that arms an acquisition.

The power-up script writes a fixed set of mode and threshold registers. It then toggles a pulse register through a long run of identical pairs, writes the device identity and closes by setting the normal channel mode. The start script writes the two comparator threshold codes and the channel mode byte, which selects the differential pairs. It then clears the identity registers and writes the identity again.

The identity, the threshold selections and the differential selection are captured when a request is accepted. Bytes leave through a valid/ready handshake, and a one-cycle done pulse marks the end of each script.

Top module: `cfg_seq_top`

## Requirements
- R1: Every command is two bytes on `out_data`. The address byte comes first and always has bit 7 set. The data byte follows. Nothing else is emitted.
- R2: The power-up script begins with these nine commands, in this order: 88/41, 89/64, 8A/64, 88/41, 88/40, 8D/01, 8D/05, 8D/01, 8D/02 (address/data, hex).
- R3: The power-up script then emits the pair 8D/06 followed by 8D/02, exactly REPEAT_PAIRS times (default 57). Next come the identity writes (R4), and the script closes with 88/40. With the defaults it is 254 bytes long.
- R4: An identity write is three commands to addresses 8C, 8E and 8F, in that order. Their data bytes are {0, id[6:0]}, {0, id[13:7]} and {0, id[20:14]}, so bit 7 of every identity data byte is 0.
- R5: The start script is 18 bytes, in this order: 89/threshold A, 8A/threshold B, 88/mode, 8C/00, 8E/00, 8F/00, then the identity write of R4.
- R6: A 3-bit threshold selection maps to a code as follows: 0 gives 2E, 1 gives 39, 2 gives 45, 3 gives 6C and 4 gives 7F. The values 5 to 7 also give 7F.
- R7: The mode byte is 40, plus 10 when `diff_sel[0]` (channels 5/6 differential) is set, plus 08 when `diff_sel[1]` (channels 7/8 differential) is set.
- R8: The identity, the threshold selections and `diff_sel` are captured on the cycle a request is accepted. Later changes to them do not alter the script in progress.
- R9: A request made while a script is running is ignored and does not cause a second script to run. When both requests arrive together while the block is idle, the power-up script runs.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds. No byte is dropped or repeated.
- R11: `done` is high for exactly one cycle: the cycle after the last byte is accepted. `out_valid` is low in that cycle.
- R12: While reset is asserted, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| init_req | input | 1 | Request to play the power-up script |
| start_req | input | 1 | Request to play the acquisition-start script |
| dev_id | input | 21 | Device identity, three 7-bit slices |
| lvl_a | input | 3 | Threshold selection for channels 1-4 |
| lvl_b | input | 3 | Threshold selection for channels 5-9 |
| diff_sel | input | 2 | Bit 0: channels 5/6 differential; bit 1: channels 7/8 differential |
| out_valid | output | 1 | A byte is presented on out_data |
| out_data | output | 8 | Command stream byte |
| out_ready | input | 1 | Downstream accepts the byte this cycle |
| done | output | 1 | One-cycle pulse after the last byte of a script is accepted |

## Verification
A request sampled at a clock edge raises `out_valid` right after that edge, with the first address byte on `out_data`. Each later byte appears right after the edge that accepts the one before it. `done` rises right after the edge that accepts the final byte and falls one edge later.

The bench changes `out_ready` and the requests only at falling edges. It samples outputs at those same falling edges. This way every comparison lands one half-period after the edge that was due to produce the value. Each byte is compared in sequence against a script built arithmetically from the configuration the bench applied. The check on `done` is made at the first falling edge after the last accepted byte.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam int LVL_W      = 3;
  localparam int ID_SLICE   = 7;
  localparam int ID_BYTES   = 3;
  localparam int ID_W       = ID_SLICE * ID_BYTES;
  localparam int PREFIX_LEN = 9;
  localparam int START_LEN  = 9;

  localparam logic [7:0] A_MODE  = 8'h88;
  localparam logic [7:0] A_THR_A = 8'h89;
  localparam logic [7:0] A_THR_B = 8'h8A;
  localparam logic [7:0] A_PULSE = 8'h8D;

  localparam logic [7:0] MODE_BASE   = 8'h40;
  localparam logic [7:0] MODE_PAIR56 = 8'h10;
  localparam logic [7:0] MODE_PAIR78 = 8'h08;
  localparam logic [7:0] PULSE_ARM   = 8'h06;
  localparam logic [7:0] PULSE_IDLE  = 8'h02;

  typedef enum logic {SEQ_INIT = 1'b0, SEQ_START = 1'b1} seq_kind_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } cmd_t;

  function automatic logic [7:0] thr_code(input logic [LVL_W-1:0] lvl);
    case (lvl)
      3'd0:    thr_code = 8'h2E;
      3'd1:    thr_code = 8'h39;
      3'd2:    thr_code = 8'h45;
      3'd3:    thr_code = 8'h6C;
      default: thr_code = 8'h7F;
    endcase
  endfunction

  function automatic logic [7:0] id_addr(input logic [1:0] k);
    case (k)
      2'd0:    id_addr = 8'h8C;
      2'd1:    id_addr = 8'h8E;
      default: id_addr = 8'h8F;
    endcase
  endfunction

  function automatic cmd_t init_prefix(input int pos);
    case (pos)
      0:       init_prefix = '{addr: A_MODE,  data: 8'h41};
      1:       init_prefix = '{addr: A_THR_A, data: 8'h64};
      2:       init_prefix = '{addr: A_THR_B, data: 8'h64};
      3:       init_prefix = '{addr: A_MODE,  data: 8'h41};
      4:       init_prefix = '{addr: A_MODE,  data: 8'h40};
      5:       init_prefix = '{addr: A_PULSE, data: 8'h01};
      6:       init_prefix = '{addr: A_PULSE, data: 8'h05};
      7:       init_prefix = '{addr: A_PULSE, data: 8'h01};
      default: init_prefix = '{addr: A_PULSE, data: 8'h02};
    endcase
  endfunction

endpackage

// File: rtl/cfg_seq_cmd.sv
module cfg_seq_cmd
  import cfg_seq_pkg::*;
#(
  parameter int REPEAT_PAIRS = 57,
  parameter int IDX_W        = 7
) (
  input  seq_kind_e        kind,
  input  logic [IDX_W-1:0] idx,
  input  logic [ID_W-1:0]  dev_id,
  input  logic [7:0]       thr_a,
  input  logic [7:0]       thr_b,
  input  logic [7:0]       mode,
  output cmd_t             cmd
);

  localparam int LOOP_END = PREFIX_LEN + 2 * REPEAT_PAIRS;
  localparam int ID_END   = LOOP_END + ID_BYTES;

  logic [7:0] id_byte [ID_BYTES];

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id_slice
    assign id_byte[g] = {1'b0, dev_id[g*ID_SLICE +: ID_SLICE]};
  end

  int         pos;
  logic [1:0] k;

  always_comb begin
    pos = int'(idx);
    k   = 2'd0;
    cmd = '{addr: A_MODE, data: MODE_BASE};
    if (kind == SEQ_INIT) begin
      if (pos < PREFIX_LEN) begin
        cmd = init_prefix(pos);
      end else if (pos < LOOP_END) begin
        cmd.addr = A_PULSE;
        cmd.data = (((pos - PREFIX_LEN) % 2) == 0) ? PULSE_ARM : PULSE_IDLE;
      end else if (pos < ID_END) begin
        k        = 2'(pos - LOOP_END);
        cmd.addr = id_addr(k);
        cmd.data = id_byte[k];
      end
    end else begin
      case (pos)
        0: cmd = '{addr: A_THR_A, data: thr_a};
        1: cmd = '{addr: A_THR_B, data: thr_b};
        2: cmd = '{addr: A_MODE,  data: mode};
        3, 4, 5: begin
          k        = 2'(pos - 3);
          cmd.addr = id_addr(k);
          cmd.data = 8'h00;
        end
        default: begin
          k        = 2'(pos - 6);
          cmd.addr = id_addr(k);
          cmd.data = id_byte[k];
        end
      endcase
    end
  end

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int INIT_LEN = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             start_req,
  input  logic             fire,
  output logic             busy,
  output seq_kind_e        kind,
  output logic [IDX_W-1:0] idx,
  output logic             phase,
  output logic             done,
  output logic             accept
);

  localparam logic [IDX_W-1:0] INIT_LAST  = IDX_W'(INIT_LEN - 1);
  localparam logic [IDX_W-1:0] START_LAST = IDX_W'(START_LEN - 1);

  logic             busy_q, busy_d;
  seq_kind_e        kind_q, kind_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             phase_q, phase_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] last_idx;

  always_comb begin
    accept   = !busy_q && (init_req || start_req);
    last_idx = (kind_q == SEQ_INIT) ? INIT_LAST : START_LAST;
    busy_d   = busy_q;
    kind_d   = kind_q;
    idx_d    = idx_q;
    phase_d  = phase_q;
    done_d   = 1'b0;
    if (accept) begin
      busy_d  = 1'b1;
      kind_d  = init_req ? SEQ_INIT : SEQ_START;
      idx_d   = '0;
      phase_d = 1'b0;
    end else if (busy_q && fire) begin
      if (!phase_q) begin
        phase_d = 1'b1;
      end else if (idx_q == last_idx) begin
        busy_d  = 1'b0;
        phase_d = 1'b0;
        done_d  = 1'b1;
      end else begin
        idx_d   = idx_q + 1'b1;
        phase_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      kind_q  <= SEQ_INIT;
      idx_q   <= '0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign busy  = busy_q;
  assign kind  = kind_q;
  assign idx   = idx_q;
  assign phase = phase_q;
  assign done  = done_q;

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int REPEAT_PAIRS = 57
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             start_req,
  input  logic [ID_W-1:0]  dev_id,
  input  logic [LVL_W-1:0] lvl_a,
  input  logic [LVL_W-1:0] lvl_b,
  input  logic [1:0]       diff_sel,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             done
);

  localparam int INIT_LEN = PREFIX_LEN + 2 * REPEAT_PAIRS + ID_BYTES + 1;
  localparam int IDX_W    = $clog2(INIT_LEN);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic             busy, byte_phase, accept, fire;
  seq_kind_e        kind;
  logic [IDX_W-1:0] idx;
  cmd_t             cmd;

  logic [ID_W-1:0] id_q;
  logic [7:0]      thr_a_q, thr_b_q, mode_q, mode_d;

  always_comb begin
    mode_d = MODE_BASE;
    if (diff_sel[0]) mode_d = mode_d | MODE_PAIR56;
    if (diff_sel[1]) mode_d = mode_d | MODE_PAIR78;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      id_q    <= '0;
      thr_a_q <= '0;
      thr_b_q <= '0;
      mode_q  <= '0;
    end else if (accept) begin
      id_q    <= dev_id;
      thr_a_q <= thr_code(lvl_a);
      thr_b_q <= thr_code(lvl_b);
      mode_q  <= mode_d;
    end
  end

  assign fire = busy && out_ready;

  cfg_seq_ctrl #(
    .IDX_W   (IDX_W),
    .INIT_LEN(INIT_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .init_req (init_req),
    .start_req(start_req),
    .fire     (fire),
    .busy     (busy),
    .kind     (kind),
    .idx      (idx),
    .phase    (byte_phase),
    .done     (done),
    .accept   (accept)
  );

  cfg_seq_cmd #(
    .REPEAT_PAIRS(REPEAT_PAIRS),
    .IDX_W       (IDX_W)
  ) u_cmd (
    .kind  (kind),
    .idx   (idx),
    .dev_id(id_q),
    .thr_a (thr_a_q),
    .thr_b (thr_b_q),
    .mode  (mode_q),
    .cmd   (cmd)
  );

  assign out_valid = busy;
  assign out_data  = byte_phase ? cmd.data : cmd.addr;

endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       done,
  input logic       phase
);

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && $past(out_valid && out_ready && phase)));

  a_r1_addr_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !phase) |-> out_data[7]);

  a_r1_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !phase) |=> (out_valid && phase));

  a_r4_id_bit7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !phase &&
     (out_data == 8'h8C || out_data == 8'h8E || out_data == 8'h8F))
    |=> !out_data[7]);

endmodule

bind cfg_seq_top cfg_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .done     (done),
  .phase    (byte_phase)
);

// File: tb/cfg_seq_top_tb.sv
`timescale 1ns/1ps
module cfg_seq_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        init_req, start_req;
  logic [20:0] dev_id;
  logic [2:0]  lvl_a, lvl_b;
  logic [1:0]  diff_sel;
  logic        out_valid, out_ready, done;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [0:255];
  int exp_n;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  cfg_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .start_req(start_req),
    .dev_id(dev_id), .lvl_a(lvl_a), .lvl_b(lvl_b), .diff_sel(diff_sel),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] thr_ref(input int l);
    case (l)
      0: thr_ref = 8'h2E;
      1: thr_ref = 8'h39;
      2: thr_ref = 8'h45;
      3: thr_ref = 8'h6C;
      default: thr_ref = 8'h7F;
    endcase
  endfunction

  task automatic push(input logic [7:0] a, input logic [7:0] d);
    exp_q[exp_n] = a; exp_q[exp_n+1] = d; exp_n += 2;
  endtask

  task automatic push_id(input logic [20:0] id);
    push(8'h8C, {1'b0, id[6:0]});
    push(8'h8E, {1'b0, id[13:7]});
    push(8'h8F, {1'b0, id[20:14]});
  endtask

  task automatic build_init(input logic [20:0] id);
    exp_n = 0;
    push(8'h88, 8'h41); push(8'h89, 8'h64); push(8'h8A, 8'h64);
    push(8'h88, 8'h41); push(8'h88, 8'h40); push(8'h8D, 8'h01);
    push(8'h8D, 8'h05); push(8'h8D, 8'h01); push(8'h8D, 8'h02);
    for (int i = 0; i < 57; i++) begin
      push(8'h8D, 8'h06); push(8'h8D, 8'h02);
    end
    push_id(id);
    push(8'h88, 8'h40);
  endtask

  task automatic build_start(input int la, input int lb, input logic [1:0] ds, input logic [20:0] id);
    exp_n = 0;
    push(8'h89, thr_ref(la));
    push(8'h8A, thr_ref(lb));
    push(8'h88, 8'h40 | (ds[0] ? 8'h10 : 8'h00) | (ds[1] ? 8'h08 : 8'h00));
    push(8'h8C, 8'h00); push(8'h8E, 8'h00); push(8'h8F, 8'h00);
    push_id(id);
  endtask

  task automatic run(input string tag, input bit do_init, input bit do_start,
                     input int rmode, input bit disturb);
    int got = 0;
    int cyc = 0;
    bit stalled = 0;
    logic [7:0] held = '0;
    bit r;
    @(negedge clk);
    init_req = do_init; start_req = do_start;
    @(negedge clk);
    init_req = 1'b0; start_req = 1'b0;
    while (got < exp_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rmode)
        0: r = 1'b1;
        1: r = (cyc % 3) != 1;
        default: r = lfsr[0];
      endcase
      out_ready = r;
      if (stalled) chk(out_valid && out_data == held, "R10 hold while stalled", {out_valid, out_data}, {1'b1, held});
      if (!out_valid) begin
        chk(1'b0, {tag, " valid dropped early"}, got, exp_n);
        break;
      end
      if (r) begin
        chk(out_data == exp_q[got], tag, out_data, exp_q[got]);
        got++;
        stalled = 0;
      end else begin
        stalled = 1;
        held = out_data;
      end
      if (disturb && cyc == 4) begin
        init_req = 1'b1; start_req = 1'b1;
        dev_id = ~dev_id; lvl_a = lvl_a + 3'd1; lvl_b = lvl_b + 3'd2; diff_sel = ~diff_sel;
      end
      if (disturb && cyc == 5) begin
        init_req = 1'b0; start_req = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    init_req = 1'b0; start_req = 1'b0;
    chk(done == 1'b1 && out_valid == 1'b0, "R11 done pulse after last byte", {done, out_valid}, 2'b10);
    @(negedge clk);
    chk(done == 1'b0 && out_valid == 1'b0, "R11/R9 done falls, no restart", {done, out_valid}, 2'b00);
    out_ready = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; init_req = 1'b0; start_req = 1'b0; out_ready = 1'b0;
    dev_id = '0; lvl_a = '0; lvl_b = '0; diff_sel = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R12 reset outputs", {out_valid, done}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R12 idle after reset", {out_valid, done}, 2'b00);

    // R2 R3 R4: power-up script, all-ones identity exposes bit 7 clearing
    dev_id = 21'h1FFFFF;
    build_init(dev_id);
    chk(exp_n == 254, "R3 script length", exp_n, 254);
    run("R2/R3/R4 init all-ones id", 1, 0, 0, 0);

    dev_id = 21'h0AA955;
    build_init(dev_id);
    run("R2/R3/R4/R10 init random ready", 1, 0, 2, 0);

    // R9: both requests together, power-up wins
    dev_id = 21'h123456;
    build_init(dev_id);
    run("R9 simultaneous requests", 1, 1, 1, 0);

    // R5 R6 R7: sweep all threshold pairs and differential modes
    for (int la = 0; la < 8; la++) begin
      for (int lb = 0; lb < 8; lb++) begin
        lvl_a = 3'(la); lvl_b = 3'(lb); diff_sel = 2'(la + lb);
        dev_id = 21'(la * 21'h2F1A3 + lb * 21'h0C5D7);
        build_start(la, lb, diff_sel, dev_id);
        run("R5/R6/R7 start sweep", 0, 1, la % 3, 0);
      end
    end

    // R8 R9: inputs and requests disturbed mid-script
    lvl_a = 3'd1; lvl_b = 3'd3; diff_sel = 2'b01; dev_id = 21'h15A5A5;
    build_start(1, 3, 2'b01, 21'h15A5A5);
    run("R8/R9 start with mid-script changes", 0, 1, 0, 1);

    dev_id = 21'h0F0F0F;
    build_init(21'h0F0F0F);
    run("R8/R9 init with mid-script changes", 1, 0, 1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule